// File: doc/BRIEF.md
# LED Driver Refresh Sequencer

This block drives a daisy chain of 16-channel, 12-bit grayscale PWM LED driver chips from a system clock. It generates the grayscale clock, the blanking signal, the latch pulse and a serial clock/data pair. It runs grayscale cycles of a fixed number of grayscale clock periods back to back. In the short blanking gap between two cycles it latches a previously shifted frame into the chips and then starts the next cycle. Frames come from an external buffer that the block reads one byte at a time. The buffer signals new content with a level flag, and the block answers with a one-cycle take pulse when it begins shifting a frame.

A parameter selects one of two update schedules. In the overlapped schedule, the frame shifts while the outputs run and is latched at the blank that follows. In the blank-contained schedule, the whole frame shifts while the outputs are blanked. The latch pulse and the release of the blank then follow immediately, so the blank is stretched by the transfer time. After reset the block shifts a burst of zero bytes and latches it, so that every driver register starts cleared. A global enable input holds the outputs blanked and the grayscale clock stopped. Changing that input requests a forced resend of the frame.

Top module: `led_refresh_seq`

## Requirements
- R1: While reset is high and just after it, `blank` is 1 and `xlat`, `gsclk` and `sclk` are 0.
- R2: After reset, before the first grayscale cycle, 25*N_CHIPS zero bytes (200 bits per chip) are shifted out with `blank` high, followed by one `xlat` pulse.
- R3: Each grayscale cycle holds `blank` low for exactly GS_COUNT `gsclk` periods. Each `gsclk` half period lasts GS_HALF system clocks.
- R4: `gsclk` is never high while `blank` is high, and it is low in the system clock just before every rising edge of `blank`.
- R5: With SEND_IN_BLANK=0, a frame of 24*N_CHIPS bytes is taken in one blank and shifted while `blank` is low. It is latched in the next blank and not in the one where it was taken. The blank lasts at most three system clocks.
- R6: With SEND_IN_BLANK=1, the frame shifts entirely while `blank` is high. The `xlat` pulse comes after the last bit, and `blank` falls after it, so the blank lasts at least the frame transfer time.
- R7: At a blank where `frame_valid` is low and no forced update is pending, no bit is shifted, `frame_take` stays low and no `xlat` follows.
- R8: A one-cycle `force_req` pulse causes the current buffer contents to be sent and latched even with `frame_valid` low.
- R9: From the second clock after `enable` goes low, `blank` stays high and `gsclk` low, and no frame is sent. Any change of `enable` requests a forced update, which is sent once the block is enabled.
- R10: `xlat` is exactly one system clock wide and occurs only while `blank` is high and `sclk` is idle.
- R11: Serial data uses clock polarity 0 and phase 0. `sclk` idles low, `sin` changes only while `sclk` is low, and each bit lasts 2*SCLK_HALF system clocks. Bytes go out in `rd_addr` order from 0, most significant bit first.
- R12: `frame_take` is a one-cycle pulse, issued only with `blank` high, in the cycle the shifting of a frame is started. `rd_addr` is 0 while idle, and `rd_data` must present the byte at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global output enable; low forces blanking |
| frame_valid | input | 1 | Buffer holds a frame not yet sent |
| force_req | input | 1 | Pulse requesting a resend of the buffer |
| frame_take | output | 1 | Pulse: frame shifting starts, buffer may mark it consumed |
| rd_addr | output | IDX_W | Byte index into the frame buffer |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| gsclk | output | 1 | Grayscale clock to the chain |
| blank | output | 1 | Blanking signal, high turns outputs off |
| xlat | output | 1 | Latch pulse moving shifted data into the output registers |
| sclk | output | 1 | Serial clock |
| sin | output | 1 | Serial data |

## Verification
A counter in the grayscale generator that is off by one shows up as a wrong number of `gsclk` periods between two blanks. This appears at the very first blank after the start-up burst. A pending-latch flag in the wrong state shows up within one blank, either as an `xlat` with no bits shifted since the last latch or as a frame that is never latched. A wrong byte index or bit order in the serializer corrupts the captured bit stream of the first frame. Each of these is compared against patterns computed in the bench.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BYTES_PER_CHIP       = 24;
    localparam int CLEAR_BYTES_PER_CHIP = 25;

    typedef enum logic [3:0] {
        ST_INIT, ST_CLEAR, ST_CLR_LAT, ST_RUN, ST_STOP,
        ST_BLANK, ST_LATCH, ST_PICK, ST_XFER, ST_XFER_LAT
    } seq_state_e;

    typedef struct packed {
        logic blank;
        logic xlat;
        logic gs_run;
    } pin_ctl_t;

    function automatic pin_ctl_t decode_pins(input seq_state_e s);
        pin_ctl_t p;
        p.gs_run = (s == ST_RUN);
        p.blank  = !(s == ST_RUN || s == ST_STOP);
        p.xlat   = (s == ST_CLR_LAT) || (s == ST_LATCH) || (s == ST_XFER_LAT);
        return p;
    endfunction
endpackage

// File: rtl/led_seq_serializer.sv
module led_seq_serializer #(
    parameter int IDX_W     = 8,
    parameter int SCLK_HALF = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             zero_fill,
    input  logic [IDX_W-1:0] nbytes,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             busy,
    output logic             sclk,
    output logic             sin
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    logic             busy_q, phase_q, zero_q;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [IDX_W-1:0] idx_q, last_q;
    logic [7:0]       shreg_q;
    logic             half_end;

    assign half_end = (div_q == DIV_W'(SCLK_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            zero_q  <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            shreg_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                div_q   <= '0;
                bit_q   <= 3'd7;
                idx_q   <= '0;
                last_q  <= nbytes - IDX_W'(1);
                zero_q  <= zero_fill;
                shreg_q <= zero_fill ? 8'h00 : rd_data;
            end
        end else if (half_end) begin
            div_q <= '0;
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                if (bit_q != 3'd0) begin
                    bit_q   <= bit_q - 3'd1;
                    shreg_q <= {shreg_q[6:0], 1'b0};
                end else if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    bit_q   <= 3'd7;
                    shreg_q <= zero_q ? 8'h00 : rd_data;
                end
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // Look one byte ahead so the next byte is ready at the boundary.
    assign rd_addr = busy_q ? idx_q + IDX_W'(1) : '0;
    assign busy    = busy_q;
    assign sclk    = busy_q & phase_q;
    assign sin     = busy_q & shreg_q[7];
endmodule

// File: rtl/led_seq_gsclk.sv
module led_seq_gsclk #(
    parameter int GS_COUNT = 4096,
    parameter int GS_HALF  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic gs,
    output logic last_edge
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV_W = (GS_HALF > 1) ? $clog2(GS_HALF) : 1;
    localparam int CNT_W = (GS_COUNT > 1) ? $clog2(GS_COUNT) : 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             gs_q, half_end;

    assign half_end  = (div_q == DIV_W'(GS_HALF - 1));
    assign last_edge = run && half_end && gs_q && (cnt_q == CNT_W'(GS_COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            cnt_q <= '0;
            gs_q  <= 1'b0;
        end else if (half_end) begin
            div_q <= '0;
            gs_q  <= !gs_q;
            if (gs_q) cnt_q <= last_edge ? '0 : cnt_q + CNT_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign gs = gs_q;
endmodule

// File: rtl/led_refresh_seq.sv
module led_refresh_seq
    import led_seq_pkg::*;
#(
    parameter int N_CHIPS       = 4,
    parameter int GS_COUNT      = 4096,
    parameter int GS_HALF       = 2,
    parameter int SCLK_HALF     = 1,
    parameter bit SEND_IN_BLANK = 1'b0,
    localparam int IDX_W        = $clog2(CLEAR_BYTES_PER_CHIP * N_CHIPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             frame_valid,
    input  logic             force_req,
    output logic             frame_take,
    output logic [IDX_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             gsclk,
    output logic             blank,
    output logic             xlat,
    output logic             sclk,
    output logic             sin
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int FRAME_BYTES = BYTES_PER_CHIP * N_CHIPS;
    localparam int CLEAR_BYTES = CLEAR_BYTES_PER_CHIP * N_CHIPS;

    seq_state_e       state_q, state_d;
    logic             force_q, pend_q, en_q;
    logic             shf_start, shf_zero, shf_busy;
    logic [IDX_W-1:0] shf_len;
    logic             gs_q, gs_last;
    pin_ctl_t         pins;

    always_comb begin
        state_d    = state_q;
        shf_start  = 1'b0;
        shf_zero   = 1'b0;
        shf_len    = IDX_W'(FRAME_BYTES);
        frame_take = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                shf_start = 1'b1;
                shf_zero  = 1'b1;
                shf_len   = IDX_W'(CLEAR_BYTES);
                state_d   = ST_CLEAR;
            end
            ST_CLEAR:    if (!shf_busy) state_d = ST_CLR_LAT;
            ST_CLR_LAT:  state_d = ST_PICK;
            ST_RUN:      if (gs_last || !enable) state_d = ST_STOP;
            ST_STOP:     state_d = ST_BLANK;
            ST_BLANK:    if (!shf_busy) state_d = pend_q ? ST_LATCH : ST_PICK;
            ST_LATCH:    state_d = ST_PICK;
            ST_PICK: begin
                if (enable) begin
                    state_d = ST_RUN;
                    if (frame_valid || force_q) begin
                        shf_start  = 1'b1;
                        frame_take = 1'b1;
                        if (SEND_IN_BLANK) state_d = ST_XFER;
                    end
                end
            end
            ST_XFER:     if (!shf_busy) state_d = ST_XFER_LAT;
            ST_XFER_LAT: state_d = ST_RUN;
            default:     state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            force_q <= 1'b1;
            pend_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= enable;
            force_q <= (force_q & ~frame_take) | force_req | (enable ^ en_q);
            if (state_q == ST_LATCH)
                pend_q <= 1'b0;
            else if (frame_take && !SEND_IN_BLANK)
                pend_q <= 1'b1;
        end
    end

    assign pins = decode_pins(state_q);

    led_seq_serializer #(
        .IDX_W     (IDX_W),
        .SCLK_HALF (SCLK_HALF)
    ) u_ser (
        .clk       (clk),
        .rst       (rst),
        .start     (shf_start),
        .zero_fill (shf_zero),
        .nbytes    (shf_len),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .busy      (shf_busy),
        .sclk      (sclk),
        .sin       (sin)
    );

    led_seq_gsclk #(
        .GS_COUNT (GS_COUNT),
        .GS_HALF  (GS_HALF)
    ) u_gs (
        .clk       (clk),
        .rst       (rst),
        .run       (pins.gs_run),
        .gs        (gs_q),
        .last_edge (gs_last)
    );

    assign gsclk = gs_q & pins.gs_run;
    assign blank = pins.blank;
    assign xlat  = pins.xlat;
endmodule

// File: rtl/led_refresh_seq_chk.sv
module led_refresh_seq_chk #(
    parameter bit SEND_IN_BLANK = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic frame_take,
    input logic gsclk,
    input logic blank,
    input logic xlat,
    input logic sclk,
    input logic sin
);
    timeunit 1ns;
    timeprecision 100ps;

    assert_gs_off_in_blank_R4: assert property (@(posedge clk) disable iff (rst)
        blank |-> !gsclk);

    assert_gap_before_blank_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(blank) |-> $past(!gsclk));

    assert_latch_in_blank_R10: assert property (@(posedge clk) disable iff (rst)
        xlat |-> (blank && !sclk));

    assert_latch_single_R10: assert property (@(posedge clk) disable iff (rst)
        xlat |=> !xlat);

    assert_sin_stable_R11: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sin));

    assert_take_in_blank_R12: assert property (@(posedge clk) disable iff (rst)
        frame_take |-> blank);

    assert_take_single_R12: assert property (@(posedge clk) disable iff (rst)
        frame_take |=> !frame_take);

    assert_disabled_dark_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable && $past(!enable) && $past(!enable, 2)) |-> (blank && !gsclk));

    generate
        if (SEND_IN_BLANK) begin : g_blank_xfer
            assert_shift_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
                sclk |-> blank);
        end
    endgenerate
endmodule

bind led_refresh_seq led_refresh_seq_chk #(.SEND_IN_BLANK(SEND_IN_BLANK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .frame_take (frame_take),
    .gsclk      (gsclk),
    .blank      (blank),
    .xlat       (xlat),
    .sclk       (sclk),
    .sin        (sin)
);

// File: tb/led_refresh_seq_test.sv
module led_seq_mon (
    input logic clk,
    input logic clr,
    input logic blank,
    input logic xlat,
    input logic gsclk,
    input logic sclk,
    input logic sin,
    input logic take
);
    timeunit 1ns;
    timeprecision 100ps;

    logic bits [0:1023];
    int bit_cnt = 0, bit_hi = 0, bit_lo = 0, ones = 0;
    int xlat_cnt = 0, xlat_bad = 0, bits_at_xlat = 0, blanks_at_xlat = 0;
    int blank_rises = 0, gs_run = 0, last_gs = 0, gs_bad_gap = 0;
    int blank_len = 0, last_blank_len = 0, max_blank = 0;
    int blank_low = 0, gs_hi = 0, takes = 0;
    logic p_sclk = 0, p_xlat = 0, p_gs = 0, p_blank = 1;

    always @(negedge clk) begin
        if (clr) begin
            bit_cnt = 0; bit_hi = 0; bit_lo = 0; ones = 0;
            xlat_cnt = 0; xlat_bad = 0; bits_at_xlat = 0; blanks_at_xlat = 0;
            blank_rises = 0; gs_run = 0; last_gs = 0; gs_bad_gap = 0;
            blank_len = 0; last_blank_len = 0; max_blank = 0;
            blank_low = 0; gs_hi = 0; takes = 0;
        end else begin
            if (sclk && !p_sclk) begin
                if (bit_cnt < 1024) bits[bit_cnt] = sin;
                bit_cnt++;
                if (sin) ones++;
                if (blank) bit_hi++; else bit_lo++;
            end
            if (xlat && !p_xlat) begin
                xlat_cnt++;
                if (!blank) xlat_bad++;
                bits_at_xlat = bit_cnt;
                blanks_at_xlat = blank_rises;
            end
            if (gsclk && !p_gs && !blank) gs_run++;
            if (gsclk) gs_hi++;
            if (take) takes++;
            if (blank) blank_len++; else blank_low++;
            if (blank && !p_blank) begin
                blank_rises++;
                last_gs = gs_run;
                gs_run = 0;
                if (p_gs) gs_bad_gap++;
            end
            if (!blank && p_blank) begin
                last_blank_len = blank_len;
                if (blank_len > max_blank) max_blank = blank_len;
                blank_len = 0;
            end
        end
        p_sclk = sclk; p_xlat = xlat; p_gs = gsclk; p_blank = blank;
    end
endmodule

module led_refresh_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCH   = 1;
    localparam int GSN   = 512;
    localparam int AW    = $clog2(25 * NCH + 1);
    localparam int FBITS = 192 * NCH;
    // Vector table: {seed, step}; byte i of the frame is seed + i*step.
    localparam logic [15:0] VEC [4] = '{16'h0001, 16'hFFFF, 16'hA500, 16'h3C11};

    logic clk = 0;
    logic rst = 1;
    logic en0 = 1, fv0 = 0, frc0 = 0, clr0 = 1;
    logic en1 = 1, fv1 = 0, frc1 = 0, clr1 = 1;
    logic [7:0] seed0 = 0, step0 = 0, seed1 = 0, step1 = 0;
    logic [AW-1:0] ra0, ra1;
    logic [7:0] rd0, rd1;
    logic take0, gs0, blank0, xlat0, sclk0, sin0;
    logic take1, gs1, blank1, xlat1, sclk1, sin1;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] s, input logic [7:0] st, input int i);
        return 8'(s + 8'(i) * st);
    endfunction

    assign rd0 = pat(seed0, step0, int'(ra0));
    assign rd1 = pat(seed1, step1, int'(ra1));

    led_refresh_seq #(.N_CHIPS(NCH), .GS_COUNT(GSN), .GS_HALF(1), .SCLK_HALF(1),
                      .SEND_IN_BLANK(1'b0)) uut (
        .clk(clk), .rst(rst), .enable(en0), .frame_valid(fv0), .force_req(frc0),
        .frame_take(take0), .rd_addr(ra0), .rd_data(rd0), .gsclk(gs0),
        .blank(blank0), .xlat(xlat0), .sclk(sclk0), .sin(sin0));

    led_refresh_seq #(.N_CHIPS(NCH), .GS_COUNT(GSN), .GS_HALF(1), .SCLK_HALF(1),
                      .SEND_IN_BLANK(1'b1)) uut_m1 (
        .clk(clk), .rst(rst), .enable(en1), .frame_valid(fv1), .force_req(frc1),
        .frame_take(take1), .rd_addr(ra1), .rd_data(rd1), .gsclk(gs1),
        .blank(blank1), .xlat(xlat1), .sclk(sclk1), .sin(sin1));

    led_seq_mon mon0 (.clk(clk), .clr(clr0), .blank(blank0), .xlat(xlat0), .gsclk(gs0),
                      .sclk(sclk0), .sin(sin0), .take(take0));
    led_seq_mon mon1 (.clk(clk), .clr(clr1), .blank(blank1), .xlat(xlat1), .gsclk(gs1),
                      .sclk(sclk1), .sin(sin1), .take(take1));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit probe(input bit m, input int kind, input int n);
        case (kind)
            0: return m ? !blank1 : !blank0;
            1: return (m ? mon1.xlat_cnt : mon0.xlat_cnt) >= n;
            2: return m ? take1 : take0;
            default: return (m ? mon1.blank_rises : mon0.blank_rises) >= n;
        endcase
    endfunction

    task automatic wait_for(input bit m, input int kind, input int n, input string req);
        int t = 0;
        while (!probe(m, kind, n) && t < 30000) begin
            tick();
            t++;
        end
        check(probe(m, kind, n), req, t, -1);
    endtask

    function automatic int frame_errs(input bit m, input logic [7:0] s, input logic [7:0] st);
        int bad = 0;
        for (int j = 0; j < FBITS; j++) begin
            logic e, g;
            e = pat(s, st, j / 8)[7 - (j % 8)];
            g = m ? mon1.bits[j] : mon0.bits[j];
            if (e !== g) bad++;
        end
        return bad;
    endfunction

    task automatic pulse_clr(input bit m);
        if (m) clr1 = 1; else clr0 = 1;
        tick();
        clr0 = 0;
        clr1 = 0;
    endtask

    initial begin
        repeat (4) tick();
        // R1: reset state of both instances
        check(blank0 && !xlat0 && !gs0 && !sclk0, "R1 reset outputs m0",
              {blank0, xlat0, gs0, sclk0}, 4'b1000);
        check(blank1 && !xlat1 && !gs1 && !sclk1, "R1 reset outputs m1",
              {blank1, xlat1, gs1, sclk1}, 4'b1000);
        rst = 0;
        clr0 = 0;
        clr1 = 0;
        tick();
        check(blank0 && !xlat0 && !gs0, "R1 just after reset", {blank0, xlat0, gs0}, 3'b100);

        // R2: clearing burst
        wait_for(0, 1, 1, "R2 clear latch timeout");
        check(mon0.bits_at_xlat == 200 * NCH, "R2 clear bit count", mon0.bits_at_xlat, 200 * NCH);
        check(mon0.ones == 0, "R2 clear bits all zero", mon0.ones, 0);
        check(mon0.bit_lo == 0 && mon0.blank_rises == 0, "R2 clear before first cycle",
              mon0.bit_lo + mon0.blank_rises, 0);

        // Start-up forced frame latched at the first blank; R3 period count
        wait_for(0, 1, 2, "R9 start-up forced latch timeout");
        check(mon0.last_gs == GSN, "R3 grayscale periods per cycle", mon0.last_gs, GSN);
        check(mon0.bit_cnt == 200 * NCH + FBITS, "R9 start-up forced frame size",
              mon0.bit_cnt, 200 * NCH + FBITS);

        // Overlapped schedule: walk the vector table
        for (int v = 0; v < 4; v++) begin
            wait_for(0, 0, 0, "R5 run wait timeout");
            tick();
            seed0 = VEC[v][15:8];
            step0 = VEC[v][7:0];
            pulse_clr(0);
            fv0 = 1;
            wait_for(0, 2, 0, "R12 take timeout");
            tick();
            fv0 = 0;
            wait_for(0, 1, 1, "R5 latch timeout");
            check(mon0.bit_cnt == FBITS, "R5 frame length", mon0.bit_cnt, FBITS);
            check(frame_errs(0, seed0, step0) == 0, "R11 bit order and content",
                  frame_errs(0, seed0, step0), 0);
            check(mon0.bit_hi == 0, "R5 shifted while blank low", mon0.bit_hi, 0);
            check(mon0.blanks_at_xlat == 2, "R5 latched at following blank",
                  mon0.blanks_at_xlat, 2);
            check(mon0.xlat_bad == 0, "R10 latch only in blank", mon0.xlat_bad, 0);
            check(mon0.takes == 1, "R12 one take per frame", mon0.takes, 1);
        end

        // R7: no new data, no force
        wait_for(0, 0, 0, "R7 run wait timeout");
        pulse_clr(0);
        wait_for(0, 3, 3, "R7 blank wait timeout");
        check(mon0.bit_cnt == 0 && mon0.takes == 0, "R7 no shift without data",
              mon0.bit_cnt + mon0.takes, 0);
        check(mon0.xlat_cnt == 0, "R7 no latch without data", mon0.xlat_cnt, 0);
        check(mon0.last_gs == GSN, "R3 idle cycle periods", mon0.last_gs, GSN);
        check(mon0.gs_bad_gap == 0, "R4 gsclk low before blank", mon0.gs_bad_gap, 0);
        check(mon0.max_blank <= 3, "R5 blank not stretched", mon0.max_blank, 3);

        // R8: forced resend without frame_valid
        wait_for(0, 0, 0, "R8 run wait timeout");
        seed0 = 8'h5A;
        step0 = 8'h03;
        pulse_clr(0);
        frc0 = 1;
        tick();
        frc0 = 0;
        wait_for(0, 1, 1, "R8 latch timeout");
        check(mon0.bit_cnt == FBITS, "R8 forced frame length", mon0.bit_cnt, FBITS);
        check(frame_errs(0, seed0, step0) == 0, "R8 forced frame content",
              frame_errs(0, seed0, step0), 0);

        // R9: global disable, then re-enable forces an update
        wait_for(0, 0, 0, "R9 run wait timeout");
        en0 = 0;
        repeat (3) tick();
        pulse_clr(0);
        repeat (3000) tick();
        check(mon0.blank_low == 0, "R9 blank held while disabled", mon0.blank_low, 0);
        check(mon0.gs_hi == 0, "R9 gsclk stopped while disabled", mon0.gs_hi, 0);
        check(mon0.bit_cnt == 0, "R9 no frame while disabled", mon0.bit_cnt, 0);
        seed0 = 8'h11;
        step0 = 8'h22;
        en0 = 1;
        wait_for(0, 1, 1, "R9 enable latch timeout");
        check(mon0.bit_cnt == FBITS && frame_errs(0, seed0, step0) == 0,
              "R9 forced update on enable", mon0.bit_cnt, FBITS);

        // R6: blank-contained schedule
        wait_for(1, 0, 0, "R6 run wait timeout");
        seed1 = 8'hC3;
        step1 = 8'h07;
        pulse_clr(1);
        fv1 = 1;
        wait_for(1, 2, 0, "R12 take timeout m1");
        tick();
        fv1 = 0;
        wait_for(1, 1, 1, "R6 latch timeout");
        check(mon1.bit_cnt == FBITS && mon1.bit_lo == 0, "R6 frame shifted in blank",
              mon1.bit_lo, 0);
        check(frame_errs(1, seed1, step1) == 0, "R11 bit content m1",
              frame_errs(1, seed1, step1), 0);
        check(mon1.blanks_at_xlat == 1 && mon1.xlat_bad == 0, "R6 latch in same blank",
              mon1.blanks_at_xlat, 1);
        wait_for(1, 0, 0, "R6 release timeout");
        tick();
        check(mon1.last_blank_len >= 2 * FBITS, "R6 blank stretched", mon1.last_blank_len,
              2 * FBITS);
        check(mon1.gs_bad_gap == 0, "R4 gap m1", mon1.gs_bad_gap, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #950000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule